// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the serial front end of a control register bank. It watches SCL and SDA with a system clock that runs much faster than the bus. It finds START, repeated START and STOP conditions and checks a fixed 7-bit device address. It then turns bus transfers into single-cycle strobes on an internal register port. SDA is driven open-drain: the block only ever pulls the line low, through an output enable.

A write transfer carries a register pointer and then one or more data bytes. Each data byte is written at the pointer, and the pointer then steps by one. A read transfer first sets the pointer with a write-direction header. The master then issues a repeated START and the read address. The block streams bytes from the pointer onward for as long as the master acknowledges them. A byte that the master does not acknowledge ends the stream.

The register bank is outside this block. The register port reads combinationally, so read data must be valid in the same cycle as the read strobe. The bus is never stretched.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, sdaOe is low, regWrEn and regRdEn are low, and regAddr is zero.
- R2: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 7'h2D). It does so by pulling SDA low during the ninth clock of that byte. Bit 0 selects the direction: 0 is write and 1 is read, so the default write byte is 0x5A and the default read byte is 0x5B.
- R3: An address byte that does not match gets no acknowledge. Every byte after it, up to the next START or STOP, also gets no acknowledge and produces no register strobe.
- R4: In a write transfer, the second byte loads the register pointer. Each later byte is acknowledged and causes exactly one regWrEn pulse, with regWrData equal to the byte and regAddr equal to the pointer.
- R5: In a burst write, data byte k (counting from 0) goes to register n+k, modulo 2^ADDR_W. The pointer steps by one after every write strobe.
- R6: After a pointer-setting write header, a repeated START and the read address byte, the block returns register n most significant bit first. sdaOe changes only while SCL is low.
- R7: Each byte the master acknowledges is followed by the next register (n+1, n+2, …). A byte the master does not acknowledge ends the stream and releases SDA. regRdEn pulses exactly once per byte transmitted, and never in two consecutive cycles.
- R8: SDA changes during the SCL-low phase, including several toggles before the final bit value, do not abort or disturb a transfer.
- R9: START and STOP are recognised only when SDA changes while SCL is high. A STOP returns the block to idle and releases SDA; bytes clocked after it without a START get no acknowledge. A START in the middle of a transfer begins a new address phase.
- R10: regRdData is sampled in the cycle in which regRdEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| regAddr | output | ADDR_W | Register pointer presented to the bank |
| regWrData | output | 8 | Write data for the bank |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdEn | output | 1 | One-cycle read strobe; the bank may clear on read |
| regRdData | input | 8 | Combinational read data from the bank |

## Verification
The bench builds the block with its default parameters: DEV_ADDR 7'h2D, an 8-bit register pointer and a two-stage synchroniser. With an 8-bit pointer, a burst that starts at 0xFE runs past the top of the map, which brings the pointer wrap into reach. The short synchroniser leaves plenty of system-clock margin inside each bus phase. That margin allows bursts of glitching SDA edges while SCL is low without crossing into the high phase. The same configuration also covers a wrong device address, a STOP in the middle of a transfer and a repeated START in the middle of a write.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_REGADDR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } engState_t;

  // strobes from the control engine to the datapath
  typedef struct packed {
    logic driveAck;
    logic txMode;
    logic loadPtr;
    logic wrStrobe;
    logic rdStrobe;
  } ctlStrb_t;

  // bus events reported by the datapath
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic ackRise;
    logic sdaBit;
  } busEv_t;

endpackage

// File: rtl/i2c_reg_slave_dp.sv
module i2c_reg_slave_dp
  import i2c_reg_slave_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrb_t          strb,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, byteFull;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] txSh;

  // input synchronisers, idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign byteFull = (bitCnt == CNT_W'(BYTE_W));

  assign ev.startEv = sclS & sclD & sdaD & ~sdaS;
  assign ev.stopEv  = sclS & sclD & ~sdaD & sdaS;
  assign ev.ackRise = sclRise & byteFull;
  assign ev.sdaBit  = sdaS;

  // bit counter: 0..7 data bits, BYTE_W marks the acknowledge slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ev.startEv || ev.stopEv) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      bitCnt <= byteFull ? '0 : bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (sclRise && !byteFull) begin
      rxByte <= {rxByte[BYTE_W-2:0], sdaS};
    end
  end

  // transmit shifter, loaded in the read-strobe cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
    end else if (regRdEn) begin
      txSh <= regRdData;
    end else if (sclFall && strb.txMode && !byteFull) begin
      txSh <= {txSh[BYTE_W-2:0], 1'b0};
    end
  end

  // open-drain driver, updated only on SCL falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
    end else if (ev.startEv || ev.stopEv) begin
      sdaOe <= 1'b0;
    end else if (sclFall) begin
      if (byteFull)         sdaOe <= strb.driveAck;
      else if (strb.txMode) sdaOe <= ~txSh[BYTE_W-1];
      else                  sdaOe <= 1'b0;
    end
  end

  // register port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regRdEn   <= 1'b0;
      regWrData <= '0;
      regAddr   <= '0;
    end else begin
      regWrEn <= strb.wrStrobe;
      regRdEn <= strb.rdStrobe;
      if (strb.wrStrobe) regWrData <= rxByte;
      if (strb.loadPtr)              regAddr <= ADDR_W'(rxByte);
      else if (regWrEn || regRdEn)   regAddr <= regAddr + ADDR_W'(1);
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) && !$past(ev.stopEv) && !$past(ev.startEv) |-> !$past(sclS)); // R6
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopEv |=> !sdaOe); // R9
  AST_WR_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn) |-> regAddr == $past(regAddr) + ADDR_W'(1)); // R5
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn)); // R4

endmodule

// File: rtl/i2c_reg_slave_ctrl.sv
module i2c_reg_slave_ctrl
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2D
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  output ctlStrb_t          strb
);

  engState_t state, stateNxt;
  logic addrHit, rdDir;

  assign addrHit = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign rdDir   = rxByte[0];

  always_comb begin
    stateNxt = state;
    if (ev.stopEv) begin
      stateNxt = ST_IDLE;
    end else if (ev.startEv) begin
      stateNxt = ST_DEVADDR;
    end else if (ev.ackRise) begin
      case (state)
        ST_DEVADDR: stateNxt = !addrHit ? ST_SKIP : (rdDir ? ST_READ : ST_REGADDR);
        ST_REGADDR: stateNxt = ST_WRITE;
        ST_READ:    stateNxt = ev.sdaBit ? ST_SKIP : ST_READ;
        default:    stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb.driveAck = ((state == ST_DEVADDR) && addrHit)
                    || (state == ST_REGADDR) || (state == ST_WRITE);
    strb.txMode   = (state == ST_READ);
    strb.loadPtr  = ev.ackRise && (state == ST_REGADDR);
    strb.wrStrobe = ev.ackRise && (state == ST_WRITE);
    strb.rdStrobe = ev.ackRise && (((state == ST_DEVADDR) && addrHit && rdDir)
                                   || ((state == ST_READ) && !ev.sdaBit));
  end

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ev.startEv && !ev.stopEv |=> state == ST_DEVADDR); // R9
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !strb.driveAck && !strb.txMode); // R3

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2D,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [7:0]        regRdData
);

  ctlStrb_t          strb;
  busEv_t            ev;
  logic [BYTE_W-1:0] rxByte;

  i2c_reg_slave_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .strb(strb)
  );

  i2c_reg_slave_dp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strb(strb), .ev(ev), .rxByte(rxByte), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

endmodule

// File: tb/i2c_reg_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_slave_tb_top;

  localparam int HALF = 20;
  localparam int Q    = 5;
  localparam logic [7:0] WR_ADDR = 8'h5A;
  localparam logic [7:0] RD_ADDR = 8'h5B;

  typedef struct packed {
    logic [7:0] base;
    logic [3:0] len;
    logic       glitch;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{8'h10, 4'd1, 1'b0, 8'hA5},
    '{8'h20, 4'd4, 1'b1, 8'h3C},
    '{8'hFE, 4'd3, 1'b0, 8'h71},
    '{8'h40, 4'd6, 1'b1, 8'hC3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic mLow = 1'b0;
  logic sdaOe, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic sdaLine;
  logic [7:0] mem [0:255];
  int nChk = 0, nBad = 0, wrCount = 0, rdCount = 0, oeHighChg = 0;
  logic prevOe = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine   = !(mLow || sdaOe);
  assign regRdData = mem[regAddr];

  i2c_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

  // register bank model and bus monitors
  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
    if (regRdEn) rdCount <= rdCount + 1;
    prevOe <= sdaOe;
    if (rstN && (sdaOe != prevOe) && sclLine) oeHighChg <= oeHighChg + 1;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic startCond();
    mLow = 1'b0; waitClk(Q);
    sclLine = 1'b1; waitClk(HALF);
    mLow = 1'b1; waitClk(HALF);
    sclLine = 1'b0; waitClk(Q);
  endtask

  task automatic stopCond();
    mLow = 1'b1; waitClk(Q);
    sclLine = 1'b1; waitClk(HALF);
    mLow = 1'b0; waitClk(HALF);
  endtask

  task automatic putBit(input logic b, input logic glitch);
    if (glitch) begin
      for (int g = 0; g < 3; g++) begin
        mLow = ~mLow; waitClk(2);
      end
    end
    mLow = !b; waitClk(Q);
    sclLine = 1'b1; waitClk(HALF);
    sclLine = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic glitch, output logic ackSeen);
    for (int i = 7; i >= 0; i--) putBit(b[i], glitch);
    mLow = 1'b0; waitClk(Q);
    sclLine = 1'b1; waitClk(HALF / 2);
    ackSeen = !sdaLine;
    waitClk(HALF / 2);
    sclLine = 1'b0; waitClk(Q);
  endtask

  task automatic getByte(input logic ackIt, output logic [7:0] d);
    mLow = 1'b0;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      waitClk(Q);
      sclLine = 1'b1; waitClk(HALF / 2);
      d = {d[6:0], sdaLine};
      waitClk(HALF / 2);
      sclLine = 1'b0; waitClk(Q);
    end
    mLow = ackIt; waitClk(Q);
    sclLine = 1'b1; waitClk(HALF);
    sclLine = 1'b0; waitClk(Q);
    mLow = 1'b0;
  endtask

  function automatic logic [7:0] dataOf(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 29) ^ 8'(k << 4);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int w0, r0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    // R1: reset state
    waitClk(5);
    chk("R1", sdaOe, 0, "sdaOe in reset");
    chk("R1", {regWrEn, regRdEn}, 0, "strobes in reset");
    rstN = 1'b1;
    waitClk(5);
    chk("R1", regAddr, 0, "regAddr after reset");
    chk("R1", sdaOe, 0, "sdaOe after reset");

    // vector table: burst write then burst random read
    for (int v = 0; v < 4; v++) begin
      w0 = wrCount;
      startCond();
      sendByte(WR_ADDR, VECS[v].glitch, ack);
      chk("R2", ack, 1, "write address ack");
      sendByte(VECS[v].base, VECS[v].glitch, ack);
      chk("R4", ack, 1, "register byte ack");
      for (int k = 0; k < int'(VECS[v].len); k++) begin
        sendByte(dataOf(VECS[v].seed, k), VECS[v].glitch, ack);
        chk("R4 R8", ack, 1, "data byte ack");
      end
      stopCond();
      chk("R4", wrCount - w0, VECS[v].len, "write strobe count");
      for (int k = 0; k < int'(VECS[v].len); k++)
        chk("R5 R8", mem[8'(VECS[v].base + k)], dataOf(VECS[v].seed, k), "written register");

      r0 = rdCount;
      startCond();
      sendByte(WR_ADDR, 1'b0, ack);
      sendByte(VECS[v].base, 1'b0, ack);
      startCond();
      sendByte(RD_ADDR, 1'b0, ack);
      chk("R2", ack, 1, "read address ack");
      for (int k = 0; k < int'(VECS[v].len); k++) begin
        getByte(k != int'(VECS[v].len) - 1, d);
        chk("R6 R7 R10", d, dataOf(VECS[v].seed, k), "read byte");
      end
      chk("R7", sdaOe, 0, "SDA released after NACK");
      stopCond();
      chk("R7", rdCount - r0, VECS[v].len, "read strobe count");
    end

    // R3: wrong device address
    w0 = wrCount; r0 = rdCount;
    startCond();
    sendByte(8'h58, 1'b0, ack);
    chk("R3", ack, 0, "mismatched address ack");
    sendByte(8'h55, 1'b0, ack);
    chk("R3", ack, 0, "byte after mismatch ack");
    sendByte(8'h66, 1'b0, ack);
    stopCond();
    chk("R3", (wrCount - w0) + (rdCount - r0), 0, "strobes after mismatch");

    // R9: STOP mid-transfer, then bytes without START are ignored
    w0 = wrCount;
    startCond();
    sendByte(WR_ADDR, 1'b0, ack);
    sendByte(8'h80, 1'b0, ack);
    stopCond();
    chk("R4", regAddr, 8'h80, "pointer loaded");
    sclLine = 1'b0; waitClk(Q);
    sendByte(WR_ADDR, 1'b0, ack);
    chk("R9", ack, 0, "no ack without START");
    sendByte(8'h99, 1'b0, ack);
    chk("R9", ack, 0, "no ack for data without START");
    stopCond();
    chk("R9", wrCount - w0, 0, "no writes after STOP");
    chk("R9", mem[8'h80], 0, "register untouched");

    // R9: repeated START inside a write begins a new address phase
    startCond();
    sendByte(WR_ADDR, 1'b0, ack);
    sendByte(8'h50, 1'b0, ack);
    sendByte(8'hD1, 1'b0, ack);
    startCond();
    sendByte(WR_ADDR, 1'b0, ack);
    chk("R9", ack, 1, "address ack after repeated START");
    sendByte(8'h60, 1'b1, ack);
    sendByte(8'hE2, 1'b1, ack);
    stopCond();
    chk("R9", mem[8'h50], 8'hD1, "first segment write");
    chk("R9", mem[8'h60], 8'hE2, "second segment write");
    chk("R9", mem[8'h51], 8'h00, "no spill past restart");

    chk("R6", oeHighChg, 0, "sdaOe changes while SCL high");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule